// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is one DMA channel. Software loads a control word together with source, destination and next-descriptor addresses through a small register write port. Writing a control word with a non-idle mode while the channel is idle starts a task. The channel copies data one transfer at a time over a single-cycle valid/ready memory port. Each transfer is a read from the source address followed by a write to the destination address. A transfer moves one byte, one half-word or one word, and each address either steps by that width or stays fixed. After a programmed number of transfers the channel gives the memory port up for one cycle so that an outside arbiter can step in. Single-transfer type gives it up after every transfer.

In chained mode the current table carries no data work. The channel reads a four-word descriptor from the next-descriptor address into its own registers and acts on that descriptor. A chain ends with a basic task, or with a descriptor whose mode is idle. When a data task finishes, the channel sets its mode field back to idle, drops busy and raises a sticky completion flag, unless the table's interrupt-mask bit is set. Bad programming sets an error flag and no data moves.

Top module: `dma_desc_chan`

## Requirements
- R1: Register index 0 is the control word, 1 the source address, 2 the destination address, 3 the next-descriptor address and 4 the status. All read back through the read port and all are zero after reset. Writes to indices 0 to 3 are ignored while busy. A control write with mode not 00, made while idle, starts the channel.
- R2: The control word fields are: mode at [1:0] (00 idle, 01 basic, 10 chained, 11 reserved), single-transfer type at bit 2, burst code at [6:4], interrupt mask at bit 7, source step at [9:8], destination step at [11:10], width at [13:12] (00 byte, 01 half-word, 10 word) and count at [29:16]. Each transfer reads at the source with mem_size equal to the width code, with the data right-aligned in mem_rdata. It then writes those low bytes to the destination.
- R3: A task performs count+1 transfers. The count field drops by one as each write completes and reads 0 once the task ends.
- R4: After each transfer, an address whose step code is 11 stays where it is. Any other step code advances the address by the width in bytes (1, 2 or 4), and the final addresses stay readable after the task.
- R5: In burst type the channel spends one cycle with no request and rearb_o high after every 2^(7-code) transfers (code 000 gives 128, code 111 gives 1), except after the last transfer. Single type does the same after every transfer, whatever the burst code.
- R6: When the last transfer completes, the mode field returns to 00 and busy falls. Status bit 0 (irq_o) is set unless the mask bit is 1.
- R7: Mode 10 reads four words with mem_size 10 at next, next+4, next+8 and next+12, in that order, into the control, source, destination and next registers, and then acts on the loaded mode. A basic task reached this way also sets status bit 1 unless it is masked. A loaded mode of 00 stops the channel with no data transfer and no flag.
- R8: Width code 11, mode 11, or a source or destination address not aligned to the width sets status bit 2. In that case no data request is issued and the mode field returns to 00.
- R9: Writing the status register clears each of bits 0 to 2 that is written as 1. If a clear and a set reach the same bit in the same cycle, the set wins.
- R10: A memory request that is not accepted is held with the same address, size and direction until mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code: 00 byte, 01 half-word, 10 word |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ready | input | 1 | Request accepted this cycle; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data, right-aligned |
| irq_o | output | 1 | Completion flag (status bit 0) |
| busy_o | output | 1 | Channel is not idle |
| rearb_o | output | 1 | Port released for re-arbitration this cycle |

## Verification
The final write of a task sets the completion flag. In the same cycle software may be clearing that flag through the status register, so the two can coincide. The bench forces mem_ready high and watches at the falling edge for the write request that carries the last transfer. It then drives the write-one-to-clear in that same cycle, so the completion and the clear land on one clock edge. The check is that irq_o and status bit 0 still read 1 afterwards, and that a later clear on its own brings them to 0.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 14;
  localparam int BCODE_W = 3;
  localparam int BLEN_W  = 2 ** BCODE_W;

  localparam logic [2:0] RIDX_CTRL = 3'd0;
  localparam logic [2:0] RIDX_SRC  = 3'd1;
  localparam logic [2:0] RIDX_DST  = 3'd2;
  localparam logic [2:0] RIDX_NEXT = 3'd3;
  localparam logic [2:0] RIDX_STAT = 3'd4;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_BASIC = 2'b01,
    MODE_CHAIN = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DISPATCH, S_FETCH, S_READ, S_WRITE, S_RELEASE
  } state_e;

  // Field positions are fixed: descriptors fetched from memory use this layout.
  typedef struct packed {
    logic [1:0]       pad_hi;
    logic [CNT_W-1:0] count;
    logic [1:0]       pad_mid;
    logic [1:0]       width;
    logic [1:0]       dstep;
    logic [1:0]       sstep;
    logic             no_irq;
    logic [2:0]       burst;
    logic             pad_lo;
    logic             single;
    logic [1:0]       mode;
  } ctrl_t;

  function automatic logic [2:0] width_bytes(input logic [1:0] width);
    case (width)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] addr_delta(input logic [1:0] step, input logic [1:0] width);
    return (step == 2'b11) ? 3'd0 : width_bytes(width);
  endfunction

  function automatic logic misaligned(input logic [1:0] lsb, input logic [1:0] width);
    case (width)
      2'b01:   return lsb[0];
      2'b10:   return |lsb;
      default: return 1'b0;
    endcase
  endfunction

  // Reversed power-of-two code: 0 -> 128 transfers, 7 -> 1 transfer.
  function automatic logic [BLEN_W-1:0] burst_len(input logic [BCODE_W-1:0] code);
    return BLEN_W'(1) << (~code);
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        step,
  input  logic [1:0]        width,
  output logic [ADDR_W-1:0] nxt,
  output logic              misal
);

  assign nxt   = cur + ADDR_W'(addr_delta(step, width));
  assign misal = misaligned(cur[1:0], width);

endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr
  import dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic               single,
  input  logic [BCODE_W-1:0] code,
  output logic               hit
);

  logic [BLEN_W-1:0] cnt_q;
  logic [BLEN_W-1:0] len;

  assign len = burst_len(code);
  assign hit = step && (single || (cnt_q == len - BLEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else if (step)       cnt_q <= cnt_q + BLEN_W'(1);
  end

  // R5
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt_q == '0) else $error("burst counter did not wrap");

  // R5
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !single |-> cnt_q < len) else $error("burst counter past burst length");

endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              irq_o,
  output logic              busy_o,
  output logic              rearb_o
);

  state_e              state_q;
  ctrl_t               ctrl_q;
  logic [ADDR_W-1:0]   src_q, dst_q, nxt_q, fbase_q;
  logic [1:0]          fidx_q;
  logic [WORD_W-1:0]   data_q;
  logic                irq_q, empty_q, err_q, chain_q;

  // Named events
  logic cfg_wr, stat_wr, start_evt, xfer_done, task_end, bad_task;
  logic set_irq, set_empty, set_err, data_phase, burst_hit;

  logic [ADDR_W-1:0] cur_a [2];
  logic [ADDR_W-1:0] nxt_a [2];
  logic [1:0]        stp_a [2];
  logic              mis_a [2];

  assign cur_a[0] = src_q;
  assign cur_a[1] = dst_q;
  assign stp_a[0] = ctrl_q.sstep;
  assign stp_a[1] = ctrl_q.dstep;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur   (cur_a[g]),
      .step  (stp_a[g]),
      .width (ctrl_q.width),
      .nxt   (nxt_a[g]),
      .misal (mis_a[g])
    );
  end

  assign data_phase = (state_q == S_READ) || (state_q == S_WRITE) || (state_q == S_RELEASE);
  assign xfer_done  = (state_q == S_WRITE) && mem_ready;

  dma_burst_ctr u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!data_phase),
    .step   (xfer_done),
    .single (ctrl_q.single),
    .code   (ctrl_q.burst),
    .hit    (burst_hit)
  );

  assign cfg_wr    = reg_we && (state_q == S_IDLE) && (reg_waddr != RIDX_STAT);
  assign stat_wr   = reg_we && (reg_waddr == RIDX_STAT);
  assign start_evt = cfg_wr && (reg_waddr == RIDX_CTRL) && (reg_wdata[1:0] != MODE_IDLE);
  assign task_end  = xfer_done && (ctrl_q.count == '0);
  assign bad_task  = (ctrl_q.mode == MODE_RSVD) ||
                     ((ctrl_q.mode == MODE_BASIC) &&
                      ((ctrl_q.width == 2'b11) || mis_a[0] || mis_a[1]));
  assign set_irq   = task_end && !ctrl_q.no_irq;
  assign set_empty = set_irq && chain_q;
  assign set_err   = (state_q == S_DISPATCH) && bad_task;

  // Memory port
  always_comb begin
    mem_req   = (state_q == S_FETCH) || (state_q == S_READ) || (state_q == S_WRITE);
    mem_we    = (state_q == S_WRITE);
    mem_size  = (state_q == S_FETCH) ? 2'b10 : ctrl_q.width;
    mem_wdata = data_q;
    unique case (state_q)
      S_FETCH: mem_addr = fbase_q + ADDR_W'({fidx_q, 2'b00});
      S_READ:  mem_addr = src_q;
      default: mem_addr = dst_q;
    endcase
  end

  // Status flags: a set in the same cycle overrides a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      empty_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (stat_wr && reg_wdata[0]) irq_q   <= 1'b0;
      if (stat_wr && reg_wdata[1]) empty_q <= 1'b0;
      if (stat_wr && reg_wdata[2]) err_q   <= 1'b0;
      if (set_irq)   irq_q   <= 1'b1;
      if (set_empty) empty_q <= 1'b1;
      if (set_err)   err_q   <= 1'b1;
    end
  end

  // Sequencer and descriptor registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      fbase_q <= '0;
      fidx_q  <= '0;
      data_q  <= '0;
      chain_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cfg_wr) begin
            unique case (reg_waddr)
              RIDX_CTRL: ctrl_q <= ctrl_t'(reg_wdata);
              RIDX_SRC:  src_q  <= reg_wdata[ADDR_W-1:0];
              RIDX_DST:  dst_q  <= reg_wdata[ADDR_W-1:0];
              default:   nxt_q  <= reg_wdata[ADDR_W-1:0];
            endcase
          end
          if (start_evt) begin
            state_q <= S_DISPATCH;
            chain_q <= 1'b0;
          end
        end
        S_DISPATCH: begin
          if (bad_task) begin
            ctrl_q.mode <= MODE_IDLE;
            state_q     <= S_IDLE;
          end else begin
            unique case (ctrl_q.mode)
              MODE_BASIC: state_q <= S_READ;
              MODE_CHAIN: begin
                fbase_q <= nxt_q;
                fidx_q  <= 2'd0;
                chain_q <= 1'b1;
                state_q <= S_FETCH;
              end
              default: state_q <= S_IDLE;
            endcase
          end
        end
        S_FETCH: begin
          if (mem_ready) begin
            unique case (fidx_q)
              2'd0:    ctrl_q <= ctrl_t'(mem_rdata);
              2'd1:    src_q  <= mem_rdata[ADDR_W-1:0];
              2'd2:    dst_q  <= mem_rdata[ADDR_W-1:0];
              default: nxt_q  <= mem_rdata[ADDR_W-1:0];
            endcase
            fidx_q <= fidx_q + 2'd1;
            if (fidx_q == 2'd3) state_q <= S_DISPATCH;
          end
        end
        S_READ: begin
          if (mem_ready) begin
            data_q  <= mem_rdata;
            state_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            src_q <= nxt_a[0];
            dst_q <= nxt_a[1];
            if (ctrl_q.count == '0) begin
              ctrl_q.mode <= MODE_IDLE;
              state_q     <= S_IDLE;
            end else begin
              ctrl_q.count <= ctrl_q.count - CNT_W'(1);
              state_q      <= burst_hit ? S_RELEASE : S_READ;
            end
          end
        end
        S_RELEASE: state_q <= S_READ;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  // Register read port
  always_comb begin
    unique case (reg_raddr)
      RIDX_CTRL: reg_rdata = ctrl_q;
      RIDX_SRC:  reg_rdata = 32'(src_q);
      RIDX_DST:  reg_rdata = 32'(dst_q);
      RIDX_NEXT: reg_rdata = 32'(nxt_q);
      RIDX_STAT: reg_rdata = {28'd0, busy_o, err_q, empty_q, irq_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_o   = irq_q;
  assign busy_o  = (state_q != S_IDLE);
  assign rearb_o = (state_q == S_RELEASE);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size))
    else $error("request dropped or changed before acceptance");

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && (ctrl_q.count != '0) |=> ctrl_q.count == $past(ctrl_q.count) - CNT_W'(1))
    else $error("count did not step down");

  // R6
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_end |=> (ctrl_q.mode == MODE_IDLE) && !busy_o)
    else $error("mode not cleared at task end");

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_end && ctrl_q.no_irq && !irq_q |=> !irq_q)
    else $error("masked task raised completion flag");

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> !mem_req && !busy_o && (ctrl_q.mode == MODE_IDLE))
    else $error("rejected task still active");

  // R5
  release_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearb_o |-> !mem_req ##1 (mem_req && !mem_we))
    else $error("release cycle not followed by a read");

endmodule

// File: tb/dma_desc_chan_tb.sv
module dma_desc_chan_tb;

  localparam int MEMB = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_o, busy_o, rearb_o;

  always #10 clk = ~clk;

  dma_desc_chan #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .irq_o(irq_o), .busy_o(busy_o), .rearb_o(rearb_o)
  );

  logic [7:0]  mem  [MEMB];
  logic [7:0]  expm [MEMB];
  logic [31:0] rd_log [64];
  int          wr_cnt, rd_n, rearb_cnt;
  logic        init_go, tb_we, rdy_rand;
  logic [9:0]  tb_addr;
  logic [31:0] tb_data;
  int          nchk, nerr;

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  // Memory model: the only writer of mem and of the counters
  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < MEMB; i++) mem[i] <= init_byte(i);
      wr_cnt <= 0; rd_n <= 0; rearb_cnt <= 0;
    end else begin
      if (tb_we)
        for (int k = 0; k < 4; k++) mem[tb_addr + 10'(k)] <= tb_data[8*k +: 8];
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (k < (mem_size == 2'b00 ? 1 : mem_size == 2'b01 ? 2 : 4))
              mem[mem_addr[9:0] + 10'(k)] <= mem_wdata[8*k +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_log[rd_n[5:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
      if (rearb_o) rearb_cnt <= rearb_cnt + 1;
    end
  end

  always_comb begin
    logic [9:0] a;
    a = mem_addr[9:0];
    case (mem_size)
      2'b00:   mem_rdata = {24'd0, mem[a]};
      2'b01:   mem_rdata = {16'd0, mem[a + 10'd1], mem[a]};
      default: mem_rdata = {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    endcase
  end

  initial begin
    mem_ready = 1'b1;
    forever begin
      @(negedge clk);
      mem_ready <= rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wbytes(input logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  function automatic int blen(input logic [2:0] code, input logic single);
    return single ? 1 : (128 >> code);
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [1:0] mode, input logic single,
      input logic [2:0] code, input logic noirq, input logic [1:0] ss, input logic [1:0] ds,
      input logic [1:0] w, input int cnt);
    return {2'b00, 14'(cnt), 2'b00, w, ds, ss, noirq, code, 1'b0, single, mode};
  endfunction

  function automatic logic [31:0] end_addr(input logic [31:0] a, input logic [1:0] st,
      input logic [1:0] w, input int n);
    return (st == 2'b11) ? a : a + 32'(n * wbytes(w));
  endfunction

  task automatic model_move(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    int w, n, sa, da;
    w = wbytes(c[13:12]); n = int'(c[29:16]) + 1; sa = int'(s); da = int'(d);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < w; k++) expm[(da + k) % MEMB] = expm[(sa + k) % MEMB];
      if (c[9:8]   != 2'b11) sa += w;
      if (c[11:10] != 2'b11) da += w;
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put_word(input int addr, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 10'(addr); tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
    for (int k = 0; k < 4; k++) expm[(addr + k) % MEMB] = d[8*k +: 8];
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    @(negedge clk);
    while (busy_o && t < 20000) begin @(negedge clk); t++; end
    chk({req, " channel idle"}, {31'd0, busy_o}, 32'd0);
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== expm[i]) bad++;
    chk({req, " memory image mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic run_basic(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    int base_rb, n;
    logic [31:0] v;
    n = int'(c[29:16]) + 1;
    base_rb = rearb_cnt;
    model_move(s, d, c);
    reg_write(3'd1, s);
    reg_write(3'd2, d);
    reg_write(3'd0, c);
    wait_idle("R1");
    check_mem("R2");
    chk("R5 release count", 32'(rearb_cnt - base_rb), 32'((n - 1) / blen(c[6:4], c[2])));
    reg_read(3'd4, v);
    chk("R6 status after task", v, {31'd0, !c[7]});
    chk("R6 irq_o", {31'd0, irq_o}, {31'd0, !c[7]});
    reg_read(3'd0, v);
    chk("R6 R3 control after task", v, {c[31:30], 14'd0, c[15:2], 2'b00});
    reg_read(3'd1, v);
    chk("R4 source end address", v, end_addr(s, c[9:8], c[13:12], n));
    reg_read(3'd2, v);
    chk("R4 destination end address", v, end_addr(d, c[11:10], c[13:12], n));
    reg_write(3'd4, 32'h7);
    reg_read(3'd4, v);
    chk("R9 status cleared", v, 32'd0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int base_w, base_r, n;
    void'($urandom(32'd20240611));
    nchk = 0; nerr = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    tb_we = 1'b0; tb_addr = '0; tb_data = '0; rdy_rand = 1'b0; init_go = 1'b1;
    for (int i = 0; i < MEMB; i++) expm[i] = init_byte(i);
    repeat (3) @(negedge clk);
    init_go = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), v);
      chk("R1 reset register value", v, 32'd0);
    end
    chk("R1 reset request", {31'd0, mem_req}, 32'd0);

    // R3 live count and R1 write ignored while busy
    base_w = wr_cnt;
    model_move(32'h80, 32'h280, mk_ctrl(2'b01, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b10, 5));
    reg_write(3'd1, 32'h80);
    reg_write(3'd2, 32'h280);
    reg_write(3'd0, mk_ctrl(2'b01, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b10, 5));
    while (wr_cnt - base_w != 3) @(negedge clk);
    reg_read(3'd0, v);
    chk("R3 count mid-task", {18'd0, v[29:16]}, 32'd2);
    reg_write(3'd1, 32'h00DEAD00);
    wait_idle("R1");
    reg_read(3'd1, v);
    chk("R1 busy write ignored", v, 32'h80 + 32'd24);
    check_mem("R2");
    reg_write(3'd4, 32'h7);

    // R9 completion and clear in the same cycle
    base_w = wr_cnt;
    model_move(32'h10, 32'h210, mk_ctrl(2'b01, 1'b1, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 3));
    reg_write(3'd1, 32'h10);
    reg_write(3'd2, 32'h210);
    reg_write(3'd0, mk_ctrl(2'b01, 1'b1, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 3));
    while (!(mem_req && mem_we && (wr_cnt - base_w == 3))) @(negedge clk);
    reg_we = 1'b1; reg_waddr = 3'd4; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9 set wins over clear", {31'd0, irq_o}, 32'd1);
    reg_write(3'd4, 32'h1);
    chk("R9 clear alone", {31'd0, irq_o}, 32'd0);
    check_mem("R2");

    // R5 burst corner cases
    run_basic(32'h0, 32'h200, mk_ctrl(2'b01, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 129));
    run_basic(32'h20, 32'h220, mk_ctrl(2'b01, 1'b0, 3'd7, 1'b0, 2'b00, 2'b00, 2'b01, 4));
    run_basic(32'h20, 32'h220, mk_ctrl(2'b01, 1'b1, 3'd0, 1'b1, 2'b00, 2'b11, 2'b10, 4));

    // R8 rejected tasks
    for (int e = 0; e < 3; e++) begin
      base_w = wr_cnt; base_r = rd_n;
      reg_write(3'd1, (e == 0) ? 32'h101 : 32'h100);
      reg_write(3'd2, 32'h200);
      reg_write(3'd0, (e == 2) ? mk_ctrl(2'b11, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 2)
                               : mk_ctrl(2'b01, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00,
                                         (e == 0) ? 2'b10 : 2'b11, 2));
      wait_idle("R8");
      reg_read(3'd4, v);
      chk("R8 error flag only", v, 32'h4);
      chk("R8 no data traffic", 32'((wr_cnt - base_w) + (rd_n - base_r)), 32'd0);
      reg_read(3'd0, v);
      chk("R8 mode cleared", {30'd0, v[1:0]}, 32'd0);
      reg_write(3'd4, 32'h4);
    end
    check_mem("R8");

    // R7 chain: descriptor A (chained) -> descriptor B (basic)
    put_word(768, mk_ctrl(2'b10, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 9));
    put_word(772, 32'h0000_0005);
    put_word(776, 32'h0000_0333);
    put_word(780, 32'd784);
    put_word(784, mk_ctrl(2'b01, 1'b0, 3'd6, 1'b0, 2'b00, 2'b00, 2'b10, 3));
    put_word(788, 32'h40);
    put_word(792, 32'h240);
    put_word(796, 32'd0);
    model_move(32'h40, 32'h240, mk_ctrl(2'b01, 1'b0, 3'd6, 1'b0, 2'b00, 2'b00, 2'b10, 3));
    base_r = rd_n;
    reg_write(3'd3, 32'd768);
    reg_write(3'd0, mk_ctrl(2'b10, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 0));
    wait_idle("R7");
    for (int i = 0; i < 8; i++)
      chk("R7 fetch order", rd_log[(base_r + i) % 64], 32'(768 + 4 * i));
    check_mem("R7");
    reg_read(3'd4, v);
    chk("R7 chain flags", v, 32'h3);
    reg_read(3'd1, v);
    chk("R7 loaded source advanced", v, 32'h50);
    reg_read(3'd3, v);
    chk("R7 next loaded", v, 32'd0);
    reg_write(3'd4, 32'h7);

    // R7 chain ending on an idle descriptor
    put_word(800, mk_ctrl(2'b00, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 2));
    put_word(804, 32'h0);
    put_word(808, 32'h200);
    put_word(812, 32'd0);
    base_w = wr_cnt;
    reg_write(3'd3, 32'd800);
    reg_write(3'd0, mk_ctrl(2'b10, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 0));
    wait_idle("R7");
    chk("R7 idle descriptor no writes", 32'(wr_cnt - base_w), 32'd0);
    reg_read(3'd4, v);
    chk("R7 idle descriptor no flags", v, 32'd0);
    reg_read(3'd0, v);
    chk("R7 idle descriptor loaded", v, mk_ctrl(2'b00, 1'b0, 3'd0, 1'b0, 2'b00, 2'b00, 2'b00, 2));

    // Random tasks with a stalling memory (R2 R3 R4 R5 R6 R10)
    rdy_rand = 1'b1;
    for (int t = 0; t < 30; t++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 2));
      n = $urandom_range(0, 20);
      run_basic(32'($urandom_range(0, 31) * 4), 32'(512 + $urandom_range(0, 31) * 4),
                mk_ctrl(2'b01, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                        1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                        2'($urandom_range(0, 3)), w, n));
    end
    rdy_rand = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule